// File: doc/BRIEF.md
# Page-Buffered Byte Memory with Write Polling

This block models a byte-wide nonvolatile memory array together with the controller that writes it a page at a time. It samples active-low chip-enable, write-enable and output-enable strobes on the system clock, along with an address bus and a split data bus (input, output and output-enable). When a read is requested, it returns the stored byte at once, the same way a static RAM would.

A write strobe starts a load period. Bytes are gathered into a page buffer in any order, and a byte written twice keeps its later value. When no further strobe arrives within a programmable load window, the controller goes busy for a programmable number of cycles. It then commits only the loaded bytes into the array. While it is busy, every read returns the last loaded byte with its top bit inverted, so software can poll for completion. A strobe that names a different page inside one load period is dropped, and it sets a sticky error flag.

Top module: `page_eeprom`

## Requirements
- R1: After reset every array byte reads 0xFF, and busy_o and page_err_o are low.
- R2: data_oe_o is high exactly when ce_ni and oe_ni are low and we_ni is high. Outside the busy period, data_o then equals the byte stored at addr_i.
- R3: addr_i[3:0] selects the byte within a 16-byte page, and the upper address bits select the page. The first accepted byte of a load period fixes the page. A later strobe in the same period that carries other page bits is dropped and raises page_err_o.
- R4: Bytes may be loaded in any order. A byte loaded twice in one load period commits the later value.
- R5: A commit updates only the bytes loaded in that load period. Every other byte of the page keeps its value.
- R6: The address is taken on the first clock that sees the write strobe active. The data is taken on the first clock that sees it inactive again.
- R7: busy_o rises LOAD_CYC clock edges after the edge that accepted the last byte. Any strobe within that window restarts the window.
- R8: busy_o stays high for WRITE_CYC clock edges. The array holds the new bytes from the edge on which busy_o falls.
- R9: While busy_o is high, a read at any address returns the last loaded byte with bit 7 inverted.
- R10: A write strobe that begins while busy_o is high has no effect on the array, and it does not change the polled byte.
- R11: A write strobe counts only while ce_ni and we_ni are low and oe_ni is high. Other combinations start no load.
- R12: Once page_err_o is set, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address: page bits above a 4-bit offset |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or polling byte |
| data_oe_o | output | 1 | Read data is driven |
| busy_o | output | 1 | Internal write in progress |
| page_err_o | output | 1 | Sticky cross-page load error |

## Verification
Reads are combinational, so the bench samples data_o one nanosecond after it sets up a read and consumes no clock. A byte is accepted on the edge that first sees the strobe released. busy_o is first seen high LOAD_CYC falling edges after the write task returns, and first seen low LOAD_CYC+WRITE_CYC falling edges after. The bench probes both sides of each boundary: one falling edge before the expected change and on the falling edge of the change. All sampling happens on falling edges, half a period away from the edges on which the design updates.

// File: rtl/eeprom_pkg.sv
`timescale 1ns/1ps
package eeprom_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned OFF_W      = 4;
  localparam int unsigned PAGE_BYTES = 1 << OFF_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} seq_st_e;
endpackage

// File: rtl/ee_strobe.sv
`timescale 1ns/1ps
module ee_strobe
  import eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              active_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              wr_act, act_q, ok_q;
  logic [ADDR_W-1:0] addr_q;

  assign wr_act = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      ok_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q <= wr_act;
      if (wr_act && !act_q) begin
        addr_q <= addr_i;
        ok_q   <= ~busy_i;  // busy decision taken at strobe start
      end
    end
  end

  assign active_o = act_q | wr_act;
  assign req_o    = act_q & ~wr_act & ok_q;
  assign addr_o   = addr_q;

  p_addr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && wr_act) |=> $stable(addr_q));
endmodule

// File: rtl/ee_seq.sv
`timescale 1ns/1ps
module ee_seq
  import eeprom_pkg::*;
#(
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned LOAD_CYC  = 64,
  parameter int unsigned WRITE_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              active_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              load_o,
  output logic              commit_o,
  output logic              busy_o,
  output logic              err_o,
  output logic [PAGE_W-1:0] page_o
);
  localparam int unsigned MAX_C = (LOAD_CYC > WRITE_CYC) ? LOAD_CYC : WRITE_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_C) + 1;

  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;
  logic              err_q, match;

  assign match    = (st_q == ST_IDLE) || (page_i == page_q);
  assign load_o   = req_i && (st_q != ST_PROG) && match;
  assign commit_o = (st_q == ST_PROG) && (cnt_q == CNT_W'(WRITE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      page_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (req_i && st_q == ST_LOAD && !match) err_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (load_o) begin
          st_q   <= ST_LOAD;
          page_q <= page_i;
          cnt_q  <= '0;
        end
        ST_LOAD: begin
          if (load_o || active_i) cnt_q <= '0;  // window restarts
          else if (cnt_q == CNT_W'(LOAD_CYC - 1)) begin
            st_q  <= ST_PROG;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PROG: begin
          if (commit_o) st_q <= ST_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_PROG);
  assign err_o  = err_q;
  assign page_o = page_q;

  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_busy_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cnt_q) == CNT_W'(WRITE_CYC - 1));
endmodule

// File: rtl/ee_page_buf.sv
`timescale 1ns/1ps
module ee_page_buf
  import eeprom_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  commit_i,
  input  logic [OFF_W-1:0]      off_i,
  input  byte_t                 data_i,
  output byte_t                 buf_o [PAGE_BYTES],
  output logic [PAGE_BYTES-1:0] mask_o,
  output byte_t                 last_o
);
  byte_t                 buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  byte_t                 last_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g]  <= '1;
        mask_q[g] <= 1'b0;
      end else if (load_i && off_i == OFF_W'(g)) begin
        buf_q[g]  <= data_i;
        mask_q[g] <= 1'b1;
      end else if (commit_i) begin
        mask_q[g] <= 1'b0;
      end
    end
    assign buf_o[g] = buf_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= '1;
    else if (load_i) last_q <= data_i;
  end

  assign mask_o = mask_q;
  assign last_o = last_q;
endmodule

// File: rtl/page_eeprom.sv
`timescale 1ns/1ps
module page_eeprom
  import eeprom_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LOAD_CYC  = 64,
  parameter int unsigned WRITE_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic              page_err_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;
  localparam int unsigned NPAGES = 1 << PAGE_W;

  logic                  stb_active, stb_req, load, commit, busy;
  logic [ADDR_W-1:0]     stb_addr;
  logic [PAGE_W-1:0]     cur_page;
  byte_t                 pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  byte_t                 last_byte;
  byte_t                 col_rd [PAGE_BYTES];
  logic [PAGE_W-1:0]     rd_page;

  ee_strobe #(.ADDR_W(ADDR_W)) u_stb (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i,
    .busy_i(busy), .active_o(stb_active), .req_o(stb_req), .addr_o(stb_addr)
  );

  ee_seq #(.PAGE_W(PAGE_W), .LOAD_CYC(LOAD_CYC), .WRITE_CYC(WRITE_CYC)) u_seq (
    .clk_i, .rst_ni, .req_i(stb_req), .active_i(stb_active),
    .page_i(stb_addr[ADDR_W-1:OFF_W]), .load_o(load), .commit_o(commit),
    .busy_o(busy), .err_o(page_err_o), .page_o(cur_page)
  );

  ee_page_buf u_buf (
    .clk_i, .rst_ni, .load_i(load), .commit_i(commit),
    .off_i(stb_addr[OFF_W-1:0]), .data_i(data_i),
    .buf_o(pbuf), .mask_o(pmask), .last_o(last_byte)
  );

  assign rd_page = addr_i[ADDR_W-1:OFF_W];

  // one column per byte offset, all committed in parallel
  for (genvar o = 0; o < PAGE_BYTES; o++) begin : g_col
    byte_t col_q [NPAGES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int p = 0; p < NPAGES; p++) col_q[p] <= '1;
      end else if (commit && pmask[o]) begin
        col_q[cur_page] <= pbuf[o];
      end
    end
    assign col_rd[o] = col_q[rd_page];
  end

  assign data_oe_o = ~ce_ni & ~oe_ni & we_ni;
  assign data_o    = busy ? {~last_byte[7], last_byte[6:0]} : col_rd[addr_i[OFF_W-1:0]];
  assign busy_o    = busy;

  p_mask_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (pmask == '0));
  p_poll_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(last_byte));
endmodule

// File: tb/page_eeprom_tb.sv
`timescale 1ns/1ps
module page_eeprom_tb;
  localparam int AW = 8;
  localparam int LC = 6;
  localparam int WC = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic doe, busy, perr;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  page_eeprom #(.ADDR_W(AW), .LOAD_CYC(LC), .WRITE_CYC(WC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .busy_o(busy), .page_err_o(perr)
  );

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic drive_wr(logic [AW-1:0] a, logic [7:0] d, logic oe_v = 1'b1, logic ce_v = 1'b0);
    @(negedge clk); ce_n = ce_v; we_n = 1'b0; oe_n = oe_v; addr = a; din = d;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1; d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic chk_rd(string tag, logic [AW-1:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_done();
    repeat (LC + WC + 1) @(negedge clk);
    chk("R8 idle", busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 err", perr, 0);
    chk_rd("R1 a00", 8'h00, 8'hFF);
    chk_rd("R1 aFF", 8'hFF, 8'hFF);
    ce_n = 0; oe_n = 0; we_n = 1; #1;
    chk("R2 oe on", doe, 1);
    we_n = 0; #1;
    chk("R2 oe off we", doe, 0);
    we_n = 1; ce_n = 1; #1;
    chk("R2 oe off ce", doe, 0);
    oe_n = 1;
  endtask

  task automatic t_single();
    drive_wr(8'h23, 8'h5A);
    repeat (LC - 1) @(negedge clk);
    chk("R7 pre", busy, 0);
    @(negedge clk);
    chk("R7 rise", busy, 1);
    chk_rd("R9 poll same", 8'h23, 8'hDA);
    chk_rd("R9 poll other", 8'h10, 8'hDA);
    repeat (WC - 1) @(negedge clk);
    chk("R8 still busy", busy, 1);
    @(negedge clk);
    chk("R8 fall", busy, 0);
    chk_rd("R8 data", 8'h23, 8'h5A);
    chk_rd("R5 neighbour", 8'h22, 8'hFF);
    chk_rd("R3 other page", 8'h33, 8'hFF);
  endtask

  task automatic t_order();
    drive_wr(8'h4F, 8'h11);
    drive_wr(8'h40, 8'h22);
    drive_wr(8'h47, 8'h33);
    drive_wr(8'h40, 8'h44);
    repeat (LC) @(negedge clk);
    chk_rd("R9 poll last", 8'h47, 8'hC4);
    repeat (WC) @(negedge clk);
    chk("R8 idle", busy, 0);
    chk_rd("R4 overwrite", 8'h40, 8'h44);
    chk_rd("R4 mid", 8'h47, 8'h33);
    chk_rd("R4 first", 8'h4F, 8'h11);
    chk_rd("R5 unloaded", 8'h41, 8'hFF);
  endtask

  task automatic t_partial();
    drive_wr(8'h41, 8'h77);
    wait_done();
    chk_rd("R5 kept", 8'h40, 8'h44);
    chk_rd("R5 new", 8'h41, 8'h77);
  endtask

  task automatic t_window();
    drive_wr(8'h50, 8'h01);
    repeat (LC - 3) @(negedge clk);
    drive_wr(8'h51, 8'h02);
    repeat (LC - 1) @(negedge clk);
    chk("R7 restart", busy, 0);
    @(negedge clk);
    chk("R7 restart rise", busy, 1);
    repeat (WC) @(negedge clk);
    chk_rd("R7 b0", 8'h50, 8'h01);
    chk_rd("R7 b1", 8'h51, 8'h02);
  endtask

  task automatic t_page_err();
    drive_wr(8'h60, 8'hA1);
    chk("R3 no err", perr, 0);
    drive_wr(8'h70, 8'hB2);
    chk("R3 err", perr, 1);
    wait_done();
    chk_rd("R3 kept", 8'h60, 8'hA1);
    chk_rd("R3 dropped", 8'h70, 8'hFF);
    drive_wr(8'h62, 8'hC3);
    wait_done();
    chk("R12 sticky", perr, 1);
    chk_rd("R12 later ok", 8'h62, 8'hC3);
  endtask

  task automatic t_busy_ignore();
    drive_wr(8'h80, 8'h99);
    repeat (LC) @(negedge clk);
    chk("R10 busy", busy, 1);
    drive_wr(8'h81, 8'h55);
    chk("R10 still busy", busy, 1);
    chk_rd("R10 poll kept", 8'h81, 8'h19);
    repeat (WC) @(negedge clk);
    chk("R10 idle", busy, 0);
    chk_rd("R10 ignored", 8'h81, 8'hFF);
    chk_rd("R10 written", 8'h80, 8'h99);
    repeat (LC + 2) @(negedge clk);
    chk("R10 no restart", busy, 0);
  endtask

  task automatic t_inhibit();
    drive_wr(8'h90, 8'h11, 1'b0, 1'b0);
    repeat (LC + 2) @(negedge clk);
    chk("R11 oe low busy", busy, 0);
    chk_rd("R11 oe low", 8'h90, 8'hFF);
    drive_wr(8'h91, 8'h22, 1'b1, 1'b1);
    repeat (LC + 2) @(negedge clk);
    chk("R11 ce high busy", busy, 0);
    chk_rd("R11 ce high", 8'h91, 8'hFF);
  endtask

  task automatic t_latch();
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = 8'hA0; din = 8'h00;
    @(negedge clk); addr = 8'hA5; din = 8'h3C;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    wait_done();
    chk_rd("R6 addr first", 8'hA0, 8'h3C);
    chk_rd("R6 addr late", 8'hA5, 8'hFF);
  endtask

  task automatic t_full();
    for (int i = 15; i >= 0; i--) drive_wr(8'hB0 | i[7:0], 8'(i * 7 + 1));
    repeat (LC) @(negedge clk);
    chk_rd("R9 full poll", 8'hB3, 8'h81);
    repeat (WC) @(negedge clk);
    for (int i = 0; i < 16; i++) chk_rd("R3 full page", 8'hB0 | i[7:0], 8'(i * 7 + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_partial();
    t_window();
    t_page_err();
    t_busy_ignore();
    t_inhibit();
    t_latch();
    t_full();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule